// File: doc/BRIEF.md
# Cascadable Synchronous Nibble Counter

The block is a 4-bit synchronous binary up-counter built to be chained into wider counters. Each stage has two count enables: a local enable and a chain enable. The stage advances on a rising clock edge only when both enables are high. Its carry output is high when all four count bits are ones and the chain enable is high. The carry drives the chain enable of the next more significant stage. An active-low synchronous clear returns the stage to zero on the next edge, and the clear overrides counting.

The top module chains a parameterised number of stages into one wide counter. The default is three stages, which gives 12 bits. On the least significant stage, the global count enable drives both enables. On every higher stage, the local enable comes from the global count enable and the chain enable comes from the carry of the stage below. The carry of the last stage is brought out so that a further block can extend the chain. The same edge updates every bit, so the wide count steps through plain binary.

Top module: `chain_counter`

## Requirements
- R1: While `clearN` is low at a rising edge, `wideCount` is 0 after that edge, whatever the value of `countEn`.
- R2: With `clearN` high and `countEn` high at a rising edge, `wideCount` after the edge equals its value before the edge plus one.
- R3: With `clearN` high and `countEn` low at a rising edge, `wideCount` keeps its value.
- R4: `carryOut` is high exactly when every bit of `wideCount` is 1 and `countEn` is high. This is the AND of each stage's four bits with that stage's chain enable.
- R5: A stage above the least significant one changes only on an enabled edge at which every lower bit of `wideCount` is 1. On such an edge the stage increments by one, modulo 16.
- R6: An enabled edge with `wideCount` at all ones (4095 by default) leaves `wideCount` at 0.
- R7: `carryOut` is combinational. With the count held at all ones, it follows a change on `countEn` within the same clock cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clearN | input | 1 | Active-low synchronous clear, overrides counting |
| countEn | input | 1 | Global count enable, drives both enables of the lowest stage |
| wideCount | output | STAGES*STAGE_WIDTH | Chained count value, lowest stage in the low bits |
| carryOut | output | 1 | Carry of the most significant stage |

## Verification
The assertions check every cycle for the following:
- the clear, hold and increment rules at the wide count (R1 to R3),
- the carry equation (R4),
- each upper stage staying still unless every lower bit is one (R5).

The wrap from all ones to zero (R6) is checked by the increment rule. Only the bench scenarios can show two further behaviours:
- the same-cycle, clock-free response of the carry to the enable (R7);
- agreement with an independent integer reference over a long run, with the enable toggled at random and a clear applied while counting.

// File: rtl/nibcnt_pkg.sv
package nibcnt_pkg;
  // Strobes from a stage's control to its datapath
  typedef struct packed {
    logic clear;
    logic step;
  } stageStrobe_t;
endpackage

// File: rtl/nibble_ctl.sv
module nibble_ctl
  import nibcnt_pkg::*;
(
  input  logic         clearN,
  input  logic         enP,
  input  logic         enT,
  output stageStrobe_t strobe
);
  always_comb begin
    strobe.clear = ~clearN;
    strobe.step  = clearN & enP & enT;
  end
endmodule

// File: rtl/nibble_dp.sv
module nibble_dp
  import nibcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  stageStrobe_t     strobe,
  input  logic             enT,
  output logic [WIDTH-1:0] count,
  output logic             carry
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] countQ;

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      countQ <= '0;
    end else if (strobe.step) begin
      countQ <= countQ + ONE;
    end
  end

  assign count = countQ;
  assign carry = (&countQ) & enT;
endmodule

// File: rtl/nibble_stage.sv
module nibble_stage
  import nibcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             enP,
  input  logic             enT,
  output logic [WIDTH-1:0] count,
  output logic             carry
);
  stageStrobe_t strobe;

  nibble_ctl u_ctl (
    .clearN(clearN),
    .enP   (enP),
    .enT   (enT),
    .strobe(strobe)
  );

  nibble_dp #(.WIDTH(WIDTH)) u_dp (
    .clk   (clk),
    .strobe(strobe),
    .enT   (enT),
    .count (count),
    .carry (carry)
  );
endmodule

// File: rtl/chain_counter.sv
module chain_counter #(
  parameter int STAGE_WIDTH = 4,
  parameter int STAGES      = 3,
  localparam int TOTAL      = STAGE_WIDTH * STAGES
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             countEn,
  output logic [TOTAL-1:0] wideCount,
  output logic             carryOut
);
  logic [STAGES:0] tChain;

  assign tChain[0] = countEn;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    nibble_stage #(.WIDTH(STAGE_WIDTH)) u_stage (
      .clk   (clk),
      .clearN(clearN),
      .enP   (countEn),
      .enT   (tChain[s]),
      .count (wideCount[s*STAGE_WIDTH +: STAGE_WIDTH]),
      .carry (tChain[s+1])
    );
  end

  assign carryOut = tChain[STAGES];
endmodule

// File: rtl/chain_counter_chk.sv
module chain_counter_chk #(
  parameter int STAGE_WIDTH = 4,
  parameter int STAGES      = 3,
  localparam int TOTAL      = STAGE_WIDTH * STAGES
) (
  input logic             clk,
  input logic             clearN,
  input logic             countEn,
  input logic [TOTAL-1:0] wideCount,
  input logic             carryOut
);
  localparam logic [TOTAL-1:0] ONE = TOTAL'(1);

  logic [1:0] edgesSeen = 2'd0;
  logic       armed;

  always_ff @(posedge clk) begin
    if (edgesSeen != 2'd2) edgesSeen <= edgesSeen + 2'd1;
  end
  assign armed = (edgesSeen == 2'd2);

  assert_clear_R1: assert property (@(posedge clk) disable iff (!armed)
    !clearN |=> wideCount == '0);

  assert_step_R2: assert property (@(posedge clk) disable iff (!armed)
    (clearN && countEn) |=> wideCount == $past(wideCount) + ONE);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!armed)
    (clearN && !countEn) |=> $stable(wideCount));

  assert_carry_R4: assert property (@(posedge clk) disable iff (!armed)
    carryOut == ((&wideCount) && countEn));

  for (genvar s = 1; s < STAGES; s++) begin : g_upper
    assert_cascade_R5: assert property (@(posedge clk) disable iff (!armed)
      (clearN && !((&wideCount[s*STAGE_WIDTH-1:0]) && countEn)) |=>
        $stable(wideCount[s*STAGE_WIDTH +: STAGE_WIDTH]));
  end
endmodule

bind chain_counter chain_counter_chk #(
  .STAGE_WIDTH(STAGE_WIDTH),
  .STAGES     (STAGES)
) u_chk (
  .clk      (clk),
  .clearN   (clearN),
  .countEn  (countEn),
  .wideCount(wideCount),
  .carryOut (carryOut)
);

// File: tb/tb_chain_counter.sv
`timescale 1ns/1ps
module tb_chain_counter;
  localparam int SW    = 4;
  localparam int NS    = 3;
  localparam int TOTAL = SW * NS;
  localparam int MAXV  = (1 << TOTAL) - 1;

  logic             clk = 1'b0;
  logic             clearN = 1'b0;
  logic             countEn = 1'b0;
  logic [TOTAL-1:0] wideCount;
  logic             carryOut;

  int checks = 0;
  int errors = 0;
  int refCount = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  chain_counter #(.STAGE_WIDTH(SW), .STAGES(NS)) dut (
    .clk      (clk),
    .clearN   (clearN),
    .countEn  (countEn),
    .wideCount(wideCount),
    .carryOut (carryOut)
  );

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply inputs at the falling edge, update the reference, sample after the rising edge.
  task automatic stepCycle(input logic clr, input logic en);
    int prev;
    @(negedge clk);
    clearN  = clr;
    countEn = en;
    #1;
    checkVal("R4 carry before edge", int'(carryOut),
             int'(clr ? (refCount == MAXV && en) : ((int'(wideCount) == MAXV) && en)));
    prev = refCount;
    if (!clr) refCount = 0;
    else if (en) refCount = (refCount + 1) & MAXV;
    @(posedge clk);
    #1;
    if (!clr) checkVal("R1 clear", int'(wideCount), 0);
    else if (!en) checkVal("R3 hold", int'(wideCount), refCount);
    else if (prev == MAXV) checkVal("R6 wrap", int'(wideCount), 0);
    else checkVal("R2 step", int'(wideCount), refCount);
    for (int s = 1; s < NS; s++) begin
      checkVal("R5 upper stage", int'((wideCount >> (s*SW)) & ((1 << SW) - 1)),
               (refCount >> (s*SW)) & ((1 << SW) - 1));
    end
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    // R1: clear from power-up, with enable high to show priority
    stepCycle(1'b0, 1'b1);
    stepCycle(1'b0, 1'b1);
    checkVal("R1 reset state", int'(wideCount), 0);
    // Random enable toggling over more than one full wrap
    for (int i = 0; i < 10000; i++) begin
      if (refCount == MAXV) begin
        // R7: carry follows the enable with no clock edge in between
        @(negedge clk);
        countEn = 1'b1;
        #1 checkVal("R7 carry rises with enable", int'(carryOut), 1);
        countEn = 1'b0;
        #1 checkVal("R7 carry falls with enable", int'(carryOut), 0);
        stepCycle(1'b1, 1'b0);
        stepCycle(1'b1, 1'b1);
      end else if (i == 6000) begin
        stepCycle(1'b0, 1'b1);
      end else begin
        stepCycle(1'b1, ($urandom % 4) != 0);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule